// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

The resolver decides, when it is asked to, whether a trap into the interrupt handler must be raised. Two request vectors feed it. One is a word of software-posted requests. The other is a word of external interrupt lines. The two sources use different level encodings. A software request is re-based so that the lowest software bit becomes level 1. An external line keeps its own bit index as its level. A higher level always overrides a lower one, so any active external line takes precedence over every software request. The result is compared with a priority level register that the block holds. A trap is taken only when the resolved level is above that register.

When a trap is taken, the block raises a one-cycle trap pulse. In the same cycle it loads a summary word and the resolved level into its output registers, and these drive the status registers elsewhere in the core. An evaluation happens only while a check is pending. The evaluation clears the pending check, and a return-from-exception event sets it again. A request for an asynchronous trap is not supported. An evaluation that sees one reports it on an error pulse instead of resolving anything.

Top module: `irq_level_resolver`

## Requirements
- R1: After reset, trap_pulse, async_err, summary_q and level_q are all zero, and check_pending is 1.
- R2: A set software bit i, with 4 <= i <= 18, gives candidate level i-3, so bit 4 maps to level 1 and bit 18 maps to level 15. The same bit i is set in the summary word.
- R3: A set external bit i, with 20 <= i <= 30, gives candidate level i, and bit i is set in the summary word.
- R4: The resolved level is the highest candidate. Any set external bit in range beats every software bit, and within one source the highest set index wins.
- R5: The summary word is the OR of the in-range software bits and the in-range external bits. Bits 0-3, 19 and 31 of either vector affect neither the summary nor the level.
- R6: A trap is taken only when the resolved level is nonzero and strictly greater than the priority level register. An equal or lower level takes no trap.
- R7: A taken trap makes trap_pulse 1 for exactly one cycle. summary_q and level_q take the new values at the same clock edge. All three are visible in the cycle after the edge that sampled eval_req.
- R8: eval_req starts an evaluation only while check_pending is 1, and every evaluation clears check_pending. A rearm pulse sets check_pending. When rearm and an evaluation fall in the same cycle, check_pending ends at 1. An eval_req while check_pending is 0 has no effect.
- R9: An evaluation with async_req high gives a one-cycle async_err pulse, takes no trap and leaves summary_q and level_q unchanged. It still clears check_pending.
- R10: The priority level register loads ipl_din when ipl_we is high, and an evaluation in the following cycle compares against the new value. summary_q and level_q hold their values whenever no trap is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ipl_we | input | 1 | Load enable for the priority level register |
| ipl_din | input | 5 | New priority level |
| rearm | input | 1 | Return-from-exception event; sets the pending check |
| eval_req | input | 1 | Check strobe |
| async_req | input | 1 | Asynchronous trap request (unsupported) |
| sw_req | input | 32 | Software request bits |
| ext_req | input | 32 | External interrupt lines |
| trap_pulse | output | 1 | One-cycle trap indication |
| summary_q | output | 32 | Summary word of the last taken trap |
| level_q | output | 5 | Resolved level of the last taken trap |
| check_pending | output | 1 | A check is due |
| async_err | output | 1 | One-cycle pulse for an unsupported asynchronous request |

## Verification
Every result registers once, so trap_pulse, summary_q, level_q and async_err are due in the cycle after the edge that samples eval_req. check_pending changes at that same edge. A priority load needs one edge before the evaluation that relies on it. The bench drives every input at the falling clock edge and reads the outputs at the next falling edge, which is half a cycle after the one register stage has updated. It reads the same outputs again one cycle later to confirm that the pulses have ended and the held values are unchanged.

// File: rtl/irl_pkg.sv
package irl_pkg;

  // Default geometry of the request vectors and level encoding
  localparam int unsigned REQ_W_DEF = 32;
  localparam int unsigned LVL_W_DEF = 5;
  localparam int unsigned SW_LO_DEF = 4;
  localparam int unsigned SW_HI_DEF = 18;
  localparam int unsigned EX_LO_DEF = 20;
  localparam int unsigned EX_HI_DEF = 30;

  // Outcome of one evaluation
  typedef struct packed {
    logic take_trap;
    logic flag_async;
  } irl_decision_t;

endpackage

// File: rtl/irl_range_scan.sv
module irl_range_scan #(
  parameter int unsigned REQ_W  = 32,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned LO     = 4,
  parameter int unsigned HI     = 18,
  parameter bit          REBASE = 1'b1
) (
  input  logic [REQ_W-1:0] req_vec,
  output logic [REQ_W-1:0] picked,
  output logic             hit,
  output logic [LVL_W-1:0] level
);

  localparam int unsigned SPAN = HI - LO + 1;
  localparam logic [REQ_W-1:0] RANGE_MASK =
    ((REQ_W'(1) << SPAN) - REQ_W'(1)) << LO;

  assign picked = req_vec & RANGE_MASK;

  // Ascending scan: the last set bit in range decides the level
  always_comb begin
    hit   = 1'b0;
    level = '0;
    for (int i = 0; i < int'(REQ_W); i++) begin
      if (picked[i]) begin
        hit = 1'b1;
        if (REBASE) level = LVL_W'(i - int'(LO) + 1);
        else        level = LVL_W'(i);
      end
    end
  end

endmodule

// File: rtl/irl_check_flag.sv
module irl_check_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic eval_req,
  output logic eval_fire,
  output logic pending_q
);

  logic pending_d;

  assign eval_fire = eval_req & pending_q;

  always_comb begin
    pending_d = pending_q;
    if (eval_fire) pending_d = 1'b0;
    if (rearm)     pending_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b1;
    else        pending_q <= pending_d;
  end

  // R8: an evaluation without a rearm leaves no check pending
  p_eval_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eval_fire) && !$past(rearm)) |-> !pending_q);

  // R8: a rearm always leaves a check pending
  p_rearm_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rearm) |-> pending_q);

endmodule

// File: rtl/irl_decide.sv
module irl_decide
  import irl_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             eval_fire,
  input  logic             async_req,
  input  logic             sw_hit,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             ext_hit,
  input  logic [LVL_W-1:0] ext_lvl,
  input  logic [LVL_W-1:0] ipl_q,
  output logic [LVL_W-1:0] win_lvl,
  output irl_decision_t    decision
);

  // External levels sit above all software levels
  always_comb begin
    if (ext_hit)     win_lvl = ext_lvl;
    else if (sw_hit) win_lvl = sw_lvl;
    else             win_lvl = '0;
  end

  always_comb begin
    decision.flag_async = eval_fire & async_req;
    decision.take_trap  = eval_fire & ~async_req &
                          (win_lvl != '0) & (win_lvl > ipl_q);
  end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irl_pkg::*;
#(
  parameter int unsigned REQ_W = REQ_W_DEF,
  parameter int unsigned LVL_W = LVL_W_DEF,
  parameter int unsigned SW_LO = SW_LO_DEF,
  parameter int unsigned SW_HI = SW_HI_DEF,
  parameter int unsigned EX_LO = EX_LO_DEF,
  parameter int unsigned EX_HI = EX_HI_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ipl_we,
  input  logic [LVL_W-1:0] ipl_din,
  input  logic             rearm,
  input  logic             eval_req,
  input  logic             async_req,
  input  logic [REQ_W-1:0] sw_req,
  input  logic [REQ_W-1:0] ext_req,
  output logic             trap_pulse,
  output logic [REQ_W-1:0] summary_q,
  output logic [LVL_W-1:0] level_q,
  output logic             check_pending,
  output logic             async_err
);

  localparam int unsigned NSRC = 2;
  localparam logic [REQ_W-1:0] EXT_MASK =
    ((REQ_W'(1) << (EX_HI - EX_LO + 1)) - REQ_W'(1)) << EX_LO;

  logic [NSRC-1:0][REQ_W-1:0] src_vec;
  logic [NSRC-1:0][REQ_W-1:0] src_pick;
  logic [NSRC-1:0]            src_hit;
  logic [NSRC-1:0][LVL_W-1:0] src_lvl;

  logic             eval_fire;
  logic [LVL_W-1:0] ipl_q, ipl_d;
  logic [LVL_W-1:0] win_lvl;
  irl_decision_t    decision;
  logic [REQ_W-1:0] summary_d;
  logic [LVL_W-1:0] level_d;
  logic             trap_d, err_d;

  assign src_vec[0] = sw_req;
  assign src_vec[1] = ext_req;

  // Source 0 is software (re-based), source 1 is external (raw index)
  for (genvar s = 0; s < int'(NSRC); s++) begin : g_src
    irl_range_scan #(
      .REQ_W (REQ_W),
      .LVL_W (LVL_W),
      .LO    ((s == 0) ? SW_LO : EX_LO),
      .HI    ((s == 0) ? SW_HI : EX_HI),
      .REBASE((s == 0) ? 1'b1 : 1'b0)
    ) u_scan (
      .req_vec(src_vec[s]),
      .picked (src_pick[s]),
      .hit    (src_hit[s]),
      .level  (src_lvl[s])
    );
  end

  irl_check_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .rearm    (rearm),
    .eval_req (eval_req),
    .eval_fire(eval_fire),
    .pending_q(check_pending)
  );

  irl_decide #(.LVL_W(LVL_W)) u_decide (
    .eval_fire(eval_fire),
    .async_req(async_req),
    .sw_hit   (src_hit[0]),
    .sw_lvl   (src_lvl[0]),
    .ext_hit  (src_hit[1]),
    .ext_lvl  (src_lvl[1]),
    .ipl_q    (ipl_q),
    .win_lvl  (win_lvl),
    .decision (decision)
  );

  // Next-state logic
  always_comb begin
    ipl_d     = ipl_we ? ipl_din : ipl_q;
    trap_d    = decision.take_trap;
    err_d     = decision.flag_async;
    summary_d = summary_q;
    level_d   = level_q;
    if (decision.take_trap) begin
      summary_d = src_pick[0] | src_pick[1];
      level_d   = win_lvl;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipl_q      <= '0;
      trap_pulse <= 1'b0;
      async_err  <= 1'b0;
      summary_q  <= '0;
      level_q    <= '0;
    end else begin
      ipl_q      <= ipl_d;
      trap_pulse <= trap_d;
      async_err  <= err_d;
      summary_q  <= summary_d;
      level_q    <= level_d;
    end
  end

  // R6: a taken trap reports a level above the priority level it was compared with
  p_above_ipl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (level_q > $past(ipl_q)));

  // R8: a trap pulse always follows an accepted evaluation
  p_trap_needs_eval_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> $past(eval_fire));

  // R10: without a trap the reported values hold
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_pulse |-> ($stable(level_q) && $stable(summary_q)));

  // R9: an asynchronous request never resolves into a trap
  p_async_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    async_err |-> (!trap_pulse && $stable(level_q)));

  // R4: an external bit in the summary means an external level won
  p_ext_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pulse && ((summary_q & EXT_MASK) != '0)) |-> (level_q >= LVL_W'(EX_LO)));

endmodule

// File: tb/irq_level_resolver_tb.sv
module irq_level_resolver_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ipl_we, rearm, eval_req, async_req;
  logic [4:0]  ipl_din;
  logic [31:0] sw_req, ext_req;
  logic        trap_pulse, check_pending, async_err;
  logic [31:0] summary_q;
  logic [4:0]  level_q;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_level_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .ipl_we(ipl_we), .ipl_din(ipl_din),
    .rearm(rearm), .eval_req(eval_req), .async_req(async_req),
    .sw_req(sw_req), .ext_req(ext_req), .trap_pulse(trap_pulse),
    .summary_q(summary_q), .level_q(level_q),
    .check_pending(check_pending), .async_err(async_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic tp,
                         input logic [31:0] sm, input logic [4:0] lv);
    chk(req, "trap_pulse", {31'd0, trap_pulse}, {31'd0, tp});
    chk(req, "summary_q", summary_q, sm);
    chk(req, "level_q", {27'd0, level_q}, {27'd0, lv});
  endtask

  task automatic set_ipl(input logic [4:0] v);
    @(negedge clk); ipl_we = 1'b1; ipl_din = v;
    @(negedge clk); ipl_we = 1'b0;
  endtask

  // Optional rearm, then one strobe; returns at the falling edge after the sampling edge
  task automatic run_eval(input logic [31:0] sw, input logic [31:0] ext,
                          input logic asy, input bit do_rearm);
    if (do_rearm) begin
      @(negedge clk); rearm = 1'b1;
      @(negedge clk); rearm = 1'b0;
    end else begin
      @(negedge clk);
    end
    sw_req = sw; ext_req = ext; async_req = asy; eval_req = 1'b1;
    @(negedge clk);
    eval_req = 1'b0; sw_req = '0; ext_req = '0; async_req = 1'b0;
  endtask

  task automatic t_reset;
    chk_out("R1", 1'b0, 32'h0, 5'd0);
    chk("R1", "check_pending", {31'd0, check_pending}, 32'd1);
    chk("R1", "async_err", {31'd0, async_err}, 32'd0);
  endtask

  task automatic t_software;
    run_eval(32'h0000_0010, 32'h0, 1'b0, 1'b1);
    chk_out("R2", 1'b1, 32'h0000_0010, 5'd1);
    @(negedge clk);
    chk_out("R7", 1'b0, 32'h0000_0010, 5'd1);
    run_eval(32'h0004_0000, 32'h0, 1'b0, 1'b1);
    chk_out("R2", 1'b1, 32'h0004_0000, 5'd15);
    run_eval(32'h0000_0240, 32'h0, 1'b0, 1'b1);
    chk_out("R4", 1'b1, 32'h0000_0240, 5'd6);
  endtask

  task automatic t_external;
    run_eval(32'h0, 32'h0010_0000, 1'b0, 1'b1);
    chk_out("R3", 1'b1, 32'h0010_0000, 5'd20);
    run_eval(32'h0, 32'h4020_0000, 1'b0, 1'b1);
    chk_out("R3", 1'b1, 32'h4020_0000, 5'd30);
  endtask

  task automatic t_mixed;
    run_eval(32'h0007_FFF0, 32'h0040_0000, 1'b0, 1'b1);
    chk_out("R4", 1'b1, 32'h0047_FFF0, 5'd22);
  endtask

  task automatic t_ignored;
    run_eval(32'h8008_000F, 32'h8008_0001, 1'b0, 1'b1);
    chk_out("R5", 1'b0, 32'h0047_FFF0, 5'd22);
    run_eval(32'h0008_0020, 32'h8000_0000, 1'b0, 1'b1);
    chk_out("R5", 1'b1, 32'h0000_0020, 5'd2);
  endtask

  task automatic t_priority;
    set_ipl(5'd15);
    run_eval(32'h0004_0000, 32'h0, 1'b0, 1'b1);
    chk_out("R6", 1'b0, 32'h0000_0020, 5'd2);
    run_eval(32'h0, 32'h0010_0000, 1'b0, 1'b1);
    chk_out("R6", 1'b1, 32'h0010_0000, 5'd20);
    set_ipl(5'd31);
    run_eval(32'h0, 32'h4000_0000, 1'b0, 1'b1);
    chk_out("R10", 1'b0, 32'h0010_0000, 5'd20);
    set_ipl(5'd29);
    run_eval(32'h0, 32'h4000_0000, 1'b0, 1'b1);
    chk_out("R10", 1'b1, 32'h4000_0000, 5'd30);
    set_ipl(5'd0);
  endtask

  task automatic t_pending;
    chk("R8", "check_pending after eval", {31'd0, check_pending}, 32'd0);
    run_eval(32'h0, 32'h0200_0000, 1'b0, 1'b0);
    chk_out("R8", 1'b0, 32'h4000_0000, 5'd30);
    chk("R8", "check_pending idle", {31'd0, check_pending}, 32'd0);
    // rearm and strobe together while nothing is pending
    @(negedge clk); rearm = 1'b1; eval_req = 1'b1; ext_req = 32'h0200_0000;
    @(negedge clk); rearm = 1'b0; eval_req = 1'b0; ext_req = '0;
    chk_out("R8", 1'b0, 32'h4000_0000, 5'd30);
    chk("R8", "check_pending rearmed", {31'd0, check_pending}, 32'd1);
    run_eval(32'h0, 32'h0200_0000, 1'b0, 1'b0);
    chk_out("R8", 1'b1, 32'h0200_0000, 5'd25);
    // rearm and strobe together while pending: evaluation runs, flag stays set
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); eval_req = 1'b1; ext_req = 32'h0020_0000;
    @(negedge clk); rearm = 1'b0; eval_req = 1'b0; ext_req = '0;
    chk_out("R8", 1'b1, 32'h0020_0000, 5'd21);
    chk("R8", "check_pending kept", {31'd0, check_pending}, 32'd1);
  endtask

  task automatic t_async;
    run_eval(32'h0, 32'h4000_0000, 1'b1, 1'b1);
    chk("R9", "async_err", {31'd0, async_err}, 32'd1);
    chk_out("R9", 1'b0, 32'h0020_0000, 5'd21);
    chk("R9", "check_pending", {31'd0, check_pending}, 32'd0);
    @(negedge clk);
    chk("R9", "async_err end", {31'd0, async_err}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ipl_we = 1'b0; ipl_din = '0; rearm = 1'b0;
    eval_req = 1'b0; async_req = 1'b0; sw_req = '0; ext_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_software();
    t_external();
    t_mixed();
    t_ignored();
    t_priority();
    t_pending();
    t_async();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule